// File: doc/BRIEF.md
# Serial NOR flash quad-enable sequencer

This block sits on the controller side of a serial NOR flash link. It switches on the flash's quad-mode enable bit, which allows the four-line read commands to be used. Software or a boot engine reads a 3-bit requirement code from bits 22:20 of the fifteenth dword of the flash's discovered parameter table. It places that code on `qer_code` and pulses `start`. The code tells the block which register holds the enable bit and which write sequence sets it.

The block issues its transactions over a byte-level command port. Each transaction carries one opcode, zero to two write bytes and an optional single read byte. A separate serializer carries out the transaction and answers with `txn_done` and the read byte. The block first reads the register that holds the enable bit and stops with success if the bit is already set. Otherwise it does a read-modify-write under a write-enable command. It then polls the status register until the device is ready and reads the register once more to confirm the bit. It finishes with a single `done` pulse, and `error` is high in that same cycle when the sequence failed.

Top module: `qe_enable_seq`

## Requirements
- R1: Code 000 (no enable bit) ends with `done`=1 and `error`=0 in the cycle after `start` is sampled, and no transaction is issued.
- R2: Codes 110 and 111 end at once with `done`=1 and `error`=1, and no transaction is issued.
- R3: Code 011 reads opcode 0x3F and tests bit 7. When that bit is clear, the block writes with opcode 0x3E and one byte: the value read, with bit 7 set.
- R4: Codes 001, 100 and 101 read opcode 0x35 and test bit 1. When that bit is clear, the block reads opcode 0x05 and then writes opcode 0x01 with two bytes. The first byte is the value read by 0x05. The second byte is the 0x35 value with bit 1 set.
- R5: Code 010 reads opcode 0x05 and tests bit 6. When that bit is clear, the block writes opcode 0x01 with one byte: the value read, with bit 6 set.
- R6: If the first read shows the enable bit already set, the block ends with success after that single transaction.
- R7: Every write transaction (opcode 0x01 or 0x3E) comes directly after a write-enable transaction, opcode 0x06, with no data bytes.
- R8: After the write, the block repeats read 0x05 until bit 0 of the byte read is 0. It then issues the code's read opcode once more, and `error` goes high if the enable bit is still clear.
- R9: If `poll_limit` consecutive polls all return bit 0 set, the block ends with `error`=1 and issues no confirming read. A limit of 0 acts as 1.
- R10: `start` has no effect while `busy` is high.
- R11: `busy` stays high from an accepted `start` until the cycle of `done`. `done` lasts exactly one cycle, and `error` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (sampled while idle) |
| qer_code | input | 3 | Requirement code from the parameter table |
| poll_limit | input | LIMIT_W | Maximum number of busy polls |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure flag, valid with `done` |
| txn_start | output | 1 | One-cycle request for a transaction |
| txn_opcode | output | 8 | Command opcode |
| txn_nwr | output | 2 | Number of write bytes (0 to 2) |
| txn_wdata | output | 16 | Write bytes; [7:0] is sent first |
| txn_rd | output | 1 | Read one byte after the write bytes |
| txn_done | input | 1 | Serializer finished the transaction |
| txn_rdata | input | 8 | Byte read, valid with `txn_done` |

## Verification
The bench builds the block with `LIMIT_W` set to 4. Poll limits of 0 through 6 can then be driven directly, so the limit-of-zero case and the timeout path are easy to reach. The flash model's busy-poll count goes past the chosen limit in some runs and stays below it in others. The serializer latency varies from 0 to 3 extra cycles. A model mode that ignores writes drives the failed-confirmation path for every code.

// File: rtl/qe_seq_pkg.sv
package qe_seq_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    QM_NONE,
    QM_SR2_B7,
    QM_SR1_B6,
    QM_CFG_B1,
    QM_BAD
  } qe_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_QE,
    ST_READ_SR1,
    ST_WREN,
    ST_WRITE,
    ST_POLL,
    ST_VERIFY
  } seq_state_e;

  localparam logic [7:0] OPC_RD_STAT  = 8'h05;
  localparam logic [7:0] OPC_RD_CFG   = 8'h35;
  localparam logic [7:0] OPC_RD_STAT2 = 8'h3F;
  localparam logic [7:0] OPC_WR_STAT2 = 8'h3E;
  localparam logic [7:0] OPC_WR_STAT  = 8'h01;
  localparam logic [7:0] OPC_WR_EN    = 8'h06;

  typedef struct packed {
    qe_mode_e   mode;
    logic [7:0] rd_op;
    logic [7:0] wr_op;
    logic [2:0] bit_idx;
    logic       two_byte;
  } qe_plan_t;

endpackage

// File: rtl/qe_plan_decode.sv
module qe_plan_decode
  import qe_seq_pkg::*;
(
  input  logic [2:0] code,
  output qe_plan_t   plan
);
  always_comb begin
    plan.mode     = QM_NONE;
    plan.rd_op    = OPC_RD_STAT;
    plan.wr_op    = OPC_WR_STAT;
    plan.bit_idx  = 3'd0;
    plan.two_byte = 1'b0;
    unique case (code)
      3'b000: plan.mode = QM_NONE;
      3'b011: begin
        plan.mode    = QM_SR2_B7;
        plan.rd_op   = OPC_RD_STAT2;
        plan.wr_op   = OPC_WR_STAT2;
        plan.bit_idx = 3'd7;
      end
      3'b010: begin
        plan.mode    = QM_SR1_B6;
        plan.rd_op   = OPC_RD_STAT;
        plan.bit_idx = 3'd6;
      end
      3'b001, 3'b100, 3'b101: begin
        plan.mode     = QM_CFG_B1;
        plan.rd_op    = OPC_RD_CFG;
        plan.bit_idx  = 3'd1;
        plan.two_byte = 1'b1;
      end
      default: plan.mode = QM_BAD;
    endcase
  end
endmodule

// File: rtl/qe_payload_build.sv
module qe_payload_build
  import qe_seq_pkg::*;
(
  input  qe_plan_t    plan,
  input  logic [7:0]  qe_byte,
  input  logic [7:0]  stat_byte,
  output logic [15:0] wdata
);
  logic [7:0] set_byte;

  always_comb begin
    set_byte = qe_byte;
    set_byte[plan.bit_idx] = 1'b1;
    if (plan.two_byte) wdata = {set_byte, stat_byte};
    else               wdata = {8'h00, set_byte};
  end
endmodule

// File: rtl/qe_poll_timer.sv
module qe_poll_timer #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               step,
  input  logic [LIMIT_W-1:0] limit,
  output logic               expire
);
  localparam int CNT_W = LIMIT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt + 1'b1;
  assign expire  = step && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clear)         cnt <= '0;
    else if (step && !expire) cnt <= cnt_inc;
  end

  // R9: a poll that does not expire leaves the count strictly under the limit
  assert_poll_count_R9: assert property (@(posedge clk) disable iff (rst)
    (step && !expire && !clear) |=> (cnt < {1'b0, $past(limit)}));
endmodule

// File: rtl/qe_enable_seq.sv
module qe_enable_seq
  import qe_seq_pkg::*;
#(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [2:0]         qer_code,
  input  logic [LIMIT_W-1:0] poll_limit,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic               txn_start,
  output logic [7:0]         txn_opcode,
  output logic [1:0]         txn_nwr,
  output logic [15:0]        txn_wdata,
  output logic               txn_rd,
  input  logic               txn_done,
  input  logic [7:0]         txn_rdata
);
  seq_state_e  state;
  qe_plan_t    plan_c, plan_q;
  logic        issued;
  logic [7:0]  qe_byte, stat_byte, prev_op;
  logic [15:0] payload;
  logic        rsp, poll_clear, poll_step, poll_expire, bit_seen;

  qe_plan_decode u_dec (.code(qer_code), .plan(plan_c));

  qe_payload_build u_pay (
    .plan(plan_q), .qe_byte(qe_byte), .stat_byte(stat_byte), .wdata(payload)
  );

  assign rsp        = (state != ST_IDLE) && issued && txn_done;
  assign poll_clear = rsp && (state == ST_WRITE);
  assign poll_step  = rsp && (state == ST_POLL) && txn_rdata[0];
  assign bit_seen   = txn_rdata[plan_q.bit_idx];

  qe_poll_timer #(.LIMIT_W(LIMIT_W)) u_tmr (
    .clk(clk), .rst(rst), .clear(poll_clear), .step(poll_step),
    .limit(poll_limit), .expire(poll_expire)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      plan_q     <= '0;
      issued     <= 1'b0;
      qe_byte    <= '0;
      stat_byte  <= '0;
      prev_op    <= '0;
      done       <= 1'b0;
      error      <= 1'b0;
      txn_start  <= 1'b0;
      txn_opcode <= '0;
      txn_nwr    <= '0;
      txn_wdata  <= '0;
      txn_rd     <= 1'b0;
    end else begin
      done      <= 1'b0;
      error     <= 1'b0;
      txn_start <= 1'b0;
      if (txn_start) prev_op <= txn_opcode;

      if (state == ST_IDLE) begin
        if (start) begin
          plan_q <= plan_c;
          issued <= 1'b0;
          unique case (plan_c.mode)
            QM_NONE: done <= 1'b1;
            QM_BAD:  begin done <= 1'b1; error <= 1'b1; end
            default: state <= ST_READ_QE;
          endcase
        end
      end else if (!issued) begin
        issued    <= 1'b1;
        txn_start <= 1'b1;
        txn_nwr   <= 2'd0;
        txn_wdata <= '0;
        txn_rd    <= 1'b1;
        unique case (state)
          ST_READ_QE, ST_VERIFY: txn_opcode <= plan_q.rd_op;
          ST_READ_SR1, ST_POLL:  txn_opcode <= OPC_RD_STAT;
          ST_WREN: begin
            txn_opcode <= OPC_WR_EN;
            txn_rd     <= 1'b0;
          end
          ST_WRITE: begin
            txn_opcode <= plan_q.wr_op;
            txn_nwr    <= plan_q.two_byte ? 2'd2 : 2'd1;
            txn_wdata  <= payload;
            txn_rd     <= 1'b0;
          end
          default: txn_opcode <= OPC_RD_STAT;
        endcase
      end else if (txn_done) begin
        issued <= 1'b0;
        unique case (state)
          ST_READ_QE: begin
            qe_byte <= txn_rdata;
            if (bit_seen) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else if (plan_q.mode == QM_CFG_B1) begin
              state <= ST_READ_SR1;
            end else begin
              state <= ST_WREN;
            end
          end
          ST_READ_SR1: begin
            stat_byte <= txn_rdata;
            state     <= ST_WREN;
          end
          ST_WREN:  state <= ST_WRITE;
          ST_WRITE: state <= ST_POLL;
          ST_POLL: begin
            if (!txn_rdata[0]) begin
              state <= ST_VERIFY;
            end else if (poll_expire) begin
              state <= ST_IDLE;
              done  <= 1'b1;
              error <= 1'b1;
            end
          end
          ST_VERIFY: begin
            state <= ST_IDLE;
            done  <= 1'b1;
            error <= !bit_seen;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R7: a status write must follow a write-enable directly
  assert_wren_before_write_R7: assert property (@(posedge clk) disable iff (rst)
    (txn_start && (txn_opcode == OPC_WR_STAT || txn_opcode == OPC_WR_STAT2))
      |-> (prev_op == OPC_WR_EN));

  // R8: the confirming read only follows a ready status poll
  assert_verify_after_poll_R8: assert property (@(posedge clk) disable iff (rst)
    (txn_start && state == ST_VERIFY) |-> (prev_op == OPC_RD_STAT));

  // R11: done lasts one cycle
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: error appears only with done
  assert_error_with_done_R11: assert property (@(posedge clk) disable iff (rst)
    error |-> done);

  // R10: transactions are requested only inside a sequence
  assert_txn_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
    txn_start |-> busy);

  // R11: a single outstanding transaction at a time
  assert_single_request_R11: assert property (@(posedge clk) disable iff (rst)
    txn_start |=> !txn_start);
endmodule

// File: tb/sim_qe_enable_seq.sv
module sim_qe_enable_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] code_i = 3'b000;
  logic [LW-1:0] limit_i = '0;
  logic busy, done, error, txn_start, txn_rd;
  logic [7:0] txn_opcode;
  logic [1:0] txn_nwr;
  logic [15:0] txn_wdata;
  logic m_done = 1'b0;
  logic [7:0] m_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qe_enable_seq #(.LIMIT_W(LW)) u0 (
    .clk(clk), .rst(rst), .start(start), .qer_code(code_i), .poll_limit(limit_i),
    .busy(busy), .done(done), .error(error), .txn_start(txn_start),
    .txn_opcode(txn_opcode), .txn_nwr(txn_nwr), .txn_wdata(txn_wdata),
    .txn_rd(txn_rd), .txn_done(m_done), .txn_rdata(m_rdata)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int done_cnt = 0;

  // flash register model with a serializer latency
  logic load = 1'b0;
  logic [7:0] p_sr1, p_sr2, p_cr;
  int p_bp, p_lat;
  bit p_stuck;
  logic [7:0] sr1, sr2, cr;
  int wip_left, lat_cnt, m_lat, m_bp;
  bit wel, pend, m_stuck;
  logic [7:0] c_op;
  logic [1:0] c_nwr;
  logic [15:0] c_wd;
  logic [7:0] log_op [0:255];
  logic [1:0] log_nwr [0:255];
  logic [15:0] log_wd [0:255];
  int log_n = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) done_cnt <= done_cnt + 1;
    m_done <= 1'b0;
    if (load) begin
      sr1 <= p_sr1 & 8'hFE; sr2 <= p_sr2; cr <= p_cr;
      wip_left <= 0; wel <= 1'b0; m_lat <= p_lat; m_bp <= p_bp; m_stuck <= p_stuck;
    end
    if (rst) begin
      pend <= 1'b0;
    end else if (txn_start) begin
      pend <= 1'b1; lat_cnt <= m_lat;
      c_op <= txn_opcode; c_nwr <= txn_nwr; c_wd <= txn_wdata;
      log_op[log_n[7:0]] <= txn_opcode;
      log_nwr[log_n[7:0]] <= txn_nwr;
      log_wd[log_n[7:0]] <= txn_wdata;
      log_n <= log_n + 1;
    end else if (pend) begin
      if (lat_cnt != 0) lat_cnt <= lat_cnt - 1;
      else begin
        pend <= 1'b0; m_done <= 1'b1; m_rdata <= 8'h00;
        case (c_op)
          8'h05: begin
            m_rdata <= {sr1[7:1], wip_left != 0};
            if (wip_left != 0) wip_left <= wip_left - 1;
          end
          8'h35: m_rdata <= cr;
          8'h3F: m_rdata <= sr2;
          8'h06: wel <= 1'b1;
          8'h01, 8'h3E: if (wel) begin
            wel <= 1'b0; wip_left <= m_bp;
            if (!m_stuck) begin
              if (c_op == 8'h3E) sr2 <= c_wd[7:0];
              else begin
                sr1 <= c_wd[7:0] & 8'hFE;
                if (c_nwr == 2'd2) cr <= c_wd[15:8];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected transaction list computed from the requirements
  logic [7:0] e_op [0:31];
  logic [1:0] e_nwr [0:31];
  logic [15:0] e_wd [0:31];
  int e_n;
  bit e_err;
  string e_tag;

  task automatic push(input logic [7:0] op, input logic [1:0] nwr, input logic [15:0] wd);
    e_op[e_n] = op; e_nwr[e_n] = nwr; e_wd[e_n] = wd; e_n++;
  endtask

  task automatic expect_seq(input logic [2:0] code, input logic [7:0] s1, s2, c,
                            input int bp, input bit stk, input int lim);
    logic [7:0] q, rop, wop, s1m;
    int b, lm;
    e_n = 0; e_err = 0; s1m = s1 & 8'hFE;
    case (code)
      3'b000: begin e_tag = "R1"; return; end
      3'b110, 3'b111: begin e_tag = "R2"; e_err = 1; return; end
      3'b011: begin e_tag = "R3"; q = s2; rop = 8'h3F; wop = 8'h3E; b = 7; end
      3'b010: begin e_tag = "R5"; q = s1m; rop = 8'h05; wop = 8'h01; b = 6; end
      default: begin e_tag = "R4"; q = c; rop = 8'h35; wop = 8'h01; b = 1; end
    endcase
    push(rop, 2'd0, 16'h0);
    if (q[b]) begin e_tag = "R6"; return; end
    if (b == 1) push(8'h05, 2'd0, 16'h0);
    push(8'h06, 2'd0, 16'h0);
    if (b == 1) push(wop, 2'd2, {c | 8'h02, s1m});
    else push(wop, 2'd1, {8'h00, q | (8'h01 << b)});
    lm = (lim == 0) ? 1 : lim;
    if (bp >= lm) begin
      for (int i = 0; i < lm; i++) push(8'h05, 2'd0, 16'h0);
      e_err = 1; e_tag = "R9";
      return;
    end
    for (int i = 0; i <= bp; i++) push(8'h05, 2'd0, 16'h0);
    push(rop, 2'd0, 16'h0);
    e_err = stk;
    e_tag = "R8";
  endtask

  task automatic run(input logic [2:0] code, input logic [7:0] s1, s2, c,
                     input int bp, input bit stk, input int lim, input int lat,
                     input bit restart);
    int base, dn0, w, n;
    bit got, busy_ok, seq_ok, wren_ok;
    logic e;
    p_sr1 = s1; p_sr2 = s2; p_cr = c; p_bp = bp; p_stuck = stk; p_lat = lat;
    load = 1'b1; @(negedge clk); load = 1'b0;
    expect_seq(code, s1, s2, c, bp, stk, lim);
    base = log_n; dn0 = done_cnt;
    code_i = code; limit_i = lim[LW-1:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0; w = 0; busy_ok = 1; e = 1'b0;
    while (!got && w < 3000) begin
      if (done) begin
        got = 1; e = error;
      end else begin
        if (!busy) busy_ok = 0;
        start = restart && (w == 3);
        if (restart && w == 3) code_i = 3'b110;
        @(negedge clk);
        start = 1'b0;
        w++;
      end
    end
    check(got, e_tag, got, 1);
    check(busy_ok, "R11 busy", busy_ok, 1);
    check(e == e_err, e_tag, e, e_err);
    @(negedge clk);
    check(!done && !error, "R11 pulse", done, 0);
    check(done_cnt - dn0 == 1, restart ? "R10" : "R11 count", done_cnt - dn0, 1);
    n = log_n - base;
    check(n == e_n, e_tag, n, e_n);
    seq_ok = 1; wren_ok = 1;
    for (int i = 0; i < n && i < e_n; i++) begin
      if (log_op[(base+i)%256] != e_op[i] || log_nwr[(base+i)%256] != e_nwr[i]) seq_ok = 0;
      if (e_nwr[i] == 2'd2 && log_wd[(base+i)%256] != e_wd[i]) seq_ok = 0;
      if (e_nwr[i] == 2'd1 && log_wd[(base+i)%256][7:0] != e_wd[i][7:0]) seq_ok = 0;
      if ((log_op[(base+i)%256] == 8'h01 || log_op[(base+i)%256] == 8'h3E) &&
          (i == 0 || log_op[(base+i-1)%256] != 8'h06)) wren_ok = 0;
    end
    if (n > 0) begin
      check(seq_ok, e_tag, seq_ok, 1);
      check(wren_ok, "R7", wren_ok, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !error && !txn_start, "reset", {busy, done, error, txn_start}, 0);
    // directed corners
    run(3'b000, 8'h00, 8'h00, 8'h00, 0, 0, 2, 0, 0);   // R1
    run(3'b110, 8'h00, 8'h00, 8'h00, 0, 0, 2, 0, 0);   // R2
    run(3'b111, 8'h00, 8'h00, 8'h00, 0, 0, 2, 1, 0);   // R2
    run(3'b011, 8'h00, 8'h35, 8'h00, 2, 0, 5, 1, 0);   // R3
    run(3'b101, 8'h9C, 8'h00, 8'h10, 1, 0, 4, 0, 0);   // R4
    run(3'b001, 8'h44, 8'h00, 8'h81, 0, 0, 3, 2, 0);   // R4
    run(3'b100, 8'h04, 8'h00, 8'h00, 3, 0, 6, 3, 0);   // R4
    run(3'b010, 8'h1C, 8'h00, 8'h00, 1, 0, 2, 0, 0);   // R5
    run(3'b011, 8'h00, 8'h80, 8'h00, 0, 0, 2, 0, 0);   // R6
    run(3'b101, 8'h00, 8'h00, 8'h02, 0, 0, 2, 0, 0);   // R6
    run(3'b010, 8'h40, 8'h00, 8'h00, 0, 0, 2, 0, 0);   // R6
    run(3'b010, 8'h00, 8'h00, 8'h00, 0, 1, 2, 0, 0);   // R8 confirm fails
    run(3'b101, 8'h00, 8'h00, 8'h00, 4, 0, 4, 1, 0);   // R9 timeout
    run(3'b011, 8'h00, 8'h00, 8'h00, 1, 0, 0, 0, 0);   // R9 limit 0 acts as 1
    run(3'b011, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 0);   // R9 limit 0, ready at once
    run(3'b101, 8'h00, 8'h00, 8'h00, 2, 0, 5, 2, 1);   // R10 start while busy
    // random mix
    for (int k = 0; k < 300; k++) begin
      run($urandom_range(7, 0), 8'($urandom), 8'($urandom), 8'($urandom),
          $urandom_range(5, 0), ($urandom_range(7, 0) == 0), $urandom_range(6, 0),
          $urandom_range(3, 0), ($urandom_range(9, 0) == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule